// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every memory access, whether the access may proceed. Software programs a control word and eight address regions through a small word-indexed register port. Each region has a base address, a power-of-two size, an enable bit and a two-bit permission code. Each access comes with an address, a privilege flag, a write flag and a flag that marks execution inside a high-priority fault or non-maskable handler. One cycle after the access is presented, the block reports whether it is permitted. It also reports which region decided the outcome, and it raises a fault strobe when the access is denied.

Among enabled regions that contain the address, the one with the highest number decides. An address that no enabled region covers falls to a background rule. Depending on a control bit, that rule either denies the access or lets privileged accesses through as region -1. A second control bit decides whether handler-context accesses are checked at all. The block only signals a fault; handling the fault is left to the rest of the system.

Top module: `mpu_region_checker`

## Requirements
- R1: The control word sits at register index 1. Bit 0 turns checking on, bit 1 keeps checking active in handler context, and bit 2 turns on the privileged background map. Bits 31:3 always read as zero.
- R2: The identity word at register index 0 reads 0x0000_0800. Bits 15:8 give the region count (8), and bit 0 = 0 means one map serves both instruction and data accesses. Writes to this index have no effect.
- R3: Region n has a base word at index 2+2n and an attribute word at index 3+2n. The base word stores address bits 31:5, and bits 4:0 read as zero. The attribute word has bit 0 as enable, bits 5:1 as the size exponent and bits 9:8 as the permission code, and all other bits read as zero. After reset, the control word and every region word read as zero.
- R4: With the enable bit at 0, every access is permitted without a fault and reports region -1 (4'hF), whatever the other control bits hold, including handler-enable = 1.
- R5: An enabled region with size exponent k covers the 2^k bytes starting at its base rounded down to a 2^k boundary. An exponent below 5 acts as 5, which gives 32 bytes.
- R6: Permission codes: 00 denies every access. 01 allows privileged access only. 10 allows privileged read and write, plus unprivileged reads. 11 allows every access.
- R7: When several enabled regions cover the address, the highest-numbered one supplies the permission, and its number is reported.
- R8: When checking is active and no enabled region covers the address with the background bit at 0, the access faults and reports region -1.
- R9: When checking is active and no enabled region covers the address with the background bit at 1, a privileged access is permitted as region -1 and an unprivileged access faults.
- R10: With the enable bit set and handler-enable at 0, an access flagged as handler context is permitted and reports region -1. With handler-enable at 1, such an access is checked normally.
- R11: The decision appears on the outputs in the cycle after the access is presented. The fault strobe is high for exactly that one cycle for each denied access. Without an access, the valid and fault outputs stay low.
- R12: After reset, the valid, permit and fault outputs are low and the region output is -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel (combinational) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_priv | input | 1 | Access is privileged |
| acc_write | input | 1 | Access is a write |
| acc_handler | input | 1 | Access made in fault/NMI handler context |
| dec_valid | output | 1 | Decision valid |
| dec_permit | output | 1 | Access permitted |
| dec_fault | output | 1 | One-cycle fault strobe for a denied access |
| dec_region | output | 4 | Deciding region number, -1 (4'hF) for background or bypass |

## Verification
The hardest situation to reach is a stack of overlapping enabled regions with differing permission codes, where the decision depends jointly on the highest-numbered match, the privilege flag, the write flag and the two control bits. Directed cases build such a stack explicitly: a large permissive region and small restrictive ones over the same base. Seeded random configurations then place many regions with small exponents inside a narrow address window, so that overlaps, near-misses at region edges and background fall-through all occur often. Random control words also mix the handler context with every control combination.

// File: rtl/mpu_chk_pkg.sv
// Shared types and constants for the memory protection region checker.
// Assumes 32-bit byte addresses and a minimum region granule of 32 bytes.
package mpu_chk_pkg;
    localparam int ADDR_W        = 32;
    localparam int MIN_SIZE_LOG2 = 5;
    localparam int BASE_W        = ADDR_W - MIN_SIZE_LOG2;

    localparam int SEL_IDENT = 0;
    localparam int SEL_CTRL  = 1;
    localparam int SEL_RGN0  = 2;

    typedef enum logic [1:0] {
        PERM_NONE        = 2'b00,
        PERM_PRIV_ONLY   = 2'b01,
        PERM_USER_RDONLY = 2'b10,
        PERM_FULL        = 2'b11
    } perm_e;

    typedef struct packed {
        logic [BASE_W-1:0] base_hi;
        logic              en;
        logic [4:0]        size_log2;
        perm_e             perm;
    } region_cfg_t;
endpackage

// File: rtl/mpu_reg_file.sv
// Register storage for the control word and the per-region words.
// Word-indexed: 0 identity (read-only), 1 control, then base/attribute
// pairs per region. Reads are combinational from reg_sel.
module mpu_reg_file
    import mpu_chk_pkg::*;
#(
    parameter  int NUM_REGIONS = 8,
    localparam int SEL_W       = $clog2(SEL_RGN0 + 2 * NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              ctrl_en,
    output logic              ctrl_hfnmi,
    output logic              ctrl_bgmap,
    output region_cfg_t       rgn_cfg [NUM_REGIONS]
);
    localparam logic [31:0] IDENT_WORD = {16'h0, 8'(NUM_REGIONS), 8'h00};

    // Control word storage: three live bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en    <= 1'b0;
            ctrl_hfnmi <= 1'b0;
            ctrl_bgmap <= 1'b0;
        end else if (we && sel == SEL_W'(SEL_CTRL)) begin
            ctrl_en    <= wdata[0];
            ctrl_hfnmi <= wdata[1];
            ctrl_bgmap <= wdata[2];
        end
    end

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
        localparam int BASE_SEL = SEL_RGN0 + 2 * i;
        localparam int ATTR_SEL = SEL_RGN0 + 2 * i + 1;
        // Per-region base and attribute storage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rgn_cfg[i] <= '0;
            end else if (we && sel == SEL_W'(BASE_SEL)) begin
                rgn_cfg[i].base_hi <= wdata[ADDR_W-1:MIN_SIZE_LOG2];
            end else if (we && sel == SEL_W'(ATTR_SEL)) begin
                rgn_cfg[i].en        <= wdata[0];
                rgn_cfg[i].size_log2 <= wdata[5:1];
                rgn_cfg[i].perm      <= perm_e'(wdata[9:8]);
            end
        end
    end

    // Read multiplexer over all words.
    always_comb begin
        rdata = '0;
        if (sel == SEL_W'(SEL_IDENT)) rdata = IDENT_WORD;
        if (sel == SEL_W'(SEL_CTRL))  rdata = {29'h0, ctrl_bgmap, ctrl_hfnmi, ctrl_en};
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (sel == SEL_W'(SEL_RGN0 + 2 * i))
                rdata = {rgn_cfg[i].base_hi, 5'h0};
            if (sel == SEL_W'(SEL_RGN0 + 2 * i + 1))
                rdata = {22'h0, rgn_cfg[i].perm, 2'b00, rgn_cfg[i].size_log2, rgn_cfg[i].en};
        end
    end

    assert_ctrl_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_W'(SEL_CTRL)) |-> (rdata[31:3] == '0));
    assert_ident_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_W'(SEL_IDENT)) |-> (rdata == IDENT_WORD));
endmodule

// File: rtl/mpu_region_match.sv
// Address comparator for one region. Assumes the size exponent is
// clamped up to the minimum granule; the base is aligned by masking.
module mpu_region_match
    import mpu_chk_pkg::*;
(
    input  region_cfg_t       cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [4:0]        eff_log2;
    logic [ADDR_W-1:0] mask;

    // Clamp the size and compare the address bits above it.
    always_comb begin
        eff_log2 = (cfg.size_log2 < 5'(MIN_SIZE_LOG2)) ? 5'(MIN_SIZE_LOG2) : cfg.size_log2;
        mask     = {ADDR_W{1'b1}} << eff_log2;
        hit      = cfg.en && ((addr & mask) == ({cfg.base_hi, 5'h0} & mask));
    end
endmodule

// File: rtl/mpu_priority_sel.sv
// Picks the highest-numbered set bit of the hit vector.
// Assumes index 0 is the lowest priority.
module mpu_priority_sel #(
    parameter  int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hit_vec,
    output logic             any_hit,
    output logic [IDX_W-1:0] win_idx
);
    // Scan upward so the last set bit wins.
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mpu_region_checker.sv
// Top of the memory protection region checker. One access decision per
// cycle, registered, so the result follows the access by one cycle.
// Assumes configuration writes are not raced against the access they
// should govern (a write takes effect for accesses in following cycles).
module mpu_region_checker
    import mpu_chk_pkg::*;
#(
    parameter  int NUM_REGIONS = 8,
    localparam int SEL_W       = $clog2(SEL_RGN0 + 2 * NUM_REGIONS),
    localparam int IDX_W       = $clog2(NUM_REGIONS),
    localparam int RGN_W       = IDX_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [SEL_W-1:0]        reg_sel,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic                    acc_valid,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic                    acc_priv,
    input  logic                    acc_write,
    input  logic                    acc_handler,
    output logic                    dec_valid,
    output logic                    dec_permit,
    output logic                    dec_fault,
    output logic signed [RGN_W-1:0] dec_region
);
    logic                    ctrl_en, ctrl_hfnmi, ctrl_bgmap;
    region_cfg_t             rgn_cfg [NUM_REGIONS];
    logic [NUM_REGIONS-1:0]  hit_vec;
    logic                    any_hit;
    logic [IDX_W-1:0]        win_idx;
    logic                    active_c;
    logic                    permit_c;
    logic [RGN_W-1:0]        region_c;
    perm_e                   perm_w;

    mpu_reg_file #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .ctrl_en(ctrl_en), .ctrl_hfnmi(ctrl_hfnmi), .ctrl_bgmap(ctrl_bgmap),
        .rgn_cfg(rgn_cfg)
    );

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_match
        mpu_region_match u_match (
            .cfg(rgn_cfg[i]), .addr(acc_addr), .hit(hit_vec[i])
        );
    end

    mpu_priority_sel #(.N(NUM_REGIONS)) u_prio (
        .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx)
    );

    // Combine control state, winning region and access attributes.
    always_comb begin
        active_c = ctrl_en && (!acc_handler || ctrl_hfnmi);
        perm_w   = rgn_cfg[win_idx].perm;
        region_c = '1;
        if (!active_c) begin
            permit_c = 1'b1;
        end else if (any_hit) begin
            region_c = {1'b0, win_idx};
            case (perm_w)
                PERM_NONE:        permit_c = 1'b0;
                PERM_PRIV_ONLY:   permit_c = acc_priv;
                PERM_USER_RDONLY: permit_c = acc_priv || !acc_write;
                default:          permit_c = 1'b1;
            endcase
        end else begin
            permit_c = ctrl_bgmap && acc_priv;
        end
    end

    // Register the decision; fault is a single-cycle strobe per denial.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_permit <= 1'b0;
            dec_fault  <= 1'b0;
            dec_region <= '1;
        end else begin
            dec_valid  <= acc_valid;
            dec_permit <= acc_valid && permit_c;
            dec_fault  <= acc_valid && !permit_c;
            dec_region <= acc_valid ? $signed(region_c) : '1;
        end
    end

    assert_disabled_permit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ctrl_en) |=> (dec_permit && !dec_fault && dec_region == '1));
    assert_highest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (hit_vec[win_idx] && ((hit_vec >> win_idx) >> 1) == '0));
    assert_unpriv_miss_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ctrl_en && !acc_handler && !any_hit && !acc_priv) |=> dec_fault);
    assert_handler_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ctrl_en && !ctrl_hfnmi && acc_handler) |=> (dec_permit && !dec_fault));
    assert_fault_is_denial_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_fault |-> (dec_valid && !dec_permit));
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!dec_valid && !dec_fault));
endmodule

// File: tb/mpu_region_checker_tb.sv
module mpu_region_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_priv = 1'b0, acc_write = 1'b0, acc_handler = 1'b0;
    logic        dec_valid, dec_permit, dec_fault;
    logic signed [3:0] dec_region;

    int checks = 0;
    int failures = 0;

    // Bench-side mirror of what has been programmed.
    logic        m_en = 0, m_hf = 0, m_bg = 0;
    logic [26:0] m_base [8];
    logic        m_ren  [8];
    logic [4:0]  m_size [8];
    logic [1:0]  m_perm [8];

    always #10 clk = ~clk;

    mpu_region_checker u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_priv(acc_priv),
        .acc_write(acc_write), .acc_handler(acc_handler),
        .dec_valid(dec_valid), .dec_permit(dec_permit),
        .dec_fault(dec_fault), .dec_region(dec_region)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1; reg_sel = 5'(sel); reg_wdata = data;
        @(negedge clk);
        reg_we = 0;
        if (sel == 1) begin m_en = data[0]; m_hf = data[1]; m_bg = data[2]; end
        if (sel >= 2 && sel < 18) begin
            if (sel % 2 == 0) m_base[(sel-2)/2] = data[31:5];
            else begin
                m_ren[(sel-2)/2] = data[0];
                m_size[(sel-2)/2] = data[5:1];
                m_perm[(sel-2)/2] = data[9:8];
            end
        end
    endtask

    task automatic rd_check(input int sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_sel = 5'(sel);
        #1;
        check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic set_region(input int n, input logic [31:0] base, input int sz, input logic [1:0] p, input bit en);
        wr(2 + 2*n, base);
        wr(3 + 2*n, {22'h0, p, 2'b00, 5'(sz), en});
    endtask

    // Expected decision computed from the requirement text.
    function automatic void model(input logic [31:0] a, input bit pv, input bit w, input bit h,
                                  output bit permit, output logic [3:0] rgn);
        int win = -1;
        for (int i = 0; i < 8; i++) begin
            int eff = (m_size[i] < 5) ? 5 : int'(m_size[i]);
            logic [63:0] sz = 64'd1 << eff;
            logic [63:0] lo = {32'h0, m_base[i], 5'h0} & ~(sz - 1);
            if (m_ren[i] && {32'h0, a} >= lo && {32'h0, a} < lo + sz) win = i;
        end
        rgn = 4'hF;
        if (!m_en || (h && !m_hf)) permit = 1;
        else if (win >= 0) begin
            rgn = 4'(win);
            case (m_perm[win])
                2'b00: permit = 0;
                2'b01: permit = pv;
                2'b10: permit = pv || !w;
                default: permit = 1;
            endcase
        end else permit = m_bg && pv;
    endfunction

    task automatic access(input logic [31:0] a, input bit pv, input bit w, input bit h, input string req);
        bit ep; logic [3:0] er;
        model(a, pv, w, h, ep, er);
        @(negedge clk);
        acc_addr = a; acc_priv = pv; acc_write = w; acc_handler = h; acc_valid = 1;
        @(negedge clk);
        acc_valid = 0;
        check(dec_valid && dec_permit == ep && dec_fault == !ep && dec_region == er, req,
              {56'h0, dec_valid, dec_permit, dec_fault, 1'b0, dec_region},
              {56'h0, 1'b1, ep, !ep, 1'b0, er});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_ren[i] = 0; m_size[i] = 0; m_perm[i] = 0; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12 reset state
        @(negedge clk);
        check(!dec_valid && !dec_permit && !dec_fault && dec_region == -4'sd1, "R12 reset outputs",
              {60'h0, dec_valid, dec_permit, dec_fault, 1'b0}, 64'h0);
        rd_check(1, 32'h0, "R3 control zero after reset");
        rd_check(5, 32'h0, "R3 region attr zero after reset");
        // R2 identity word, writes ignored
        rd_check(0, 32'h0000_0800, "R2 identity word");
        wr(0, 32'hFFFF_FFFF);
        rd_check(0, 32'h0000_0800, "R2 identity write ignored");
        // R1 reserved control bits
        wr(1, 32'hFFFF_FFF8);
        rd_check(1, 32'h0, "R1 reserved bits read zero");
        wr(1, 32'hFFFF_FFFF);
        rd_check(1, 32'h7, "R1 live bits");
        // R3 region word layout
        wr(16, 32'hFFFF_FFFF);
        rd_check(16, 32'hFFFF_FFE0, "R3 base word layout");
        wr(17, 32'hFFFF_FFFF);
        rd_check(17, 32'h0000_033F, "R3 attr word layout");
        set_region(7, 0, 0, 2'b00, 0);
        // R4 disabled, handler-enable set, deny region covering address
        wr(1, 32'h2);
        set_region(0, 32'h1000, 8, 2'b00, 1);
        access(32'h1010, 0, 1, 0, "R4 disabled permits");
        access(32'h1010, 0, 1, 1, "R4 disabled handler permits");
        // R8 active, no background
        wr(1, 32'h1);
        access(32'h1010, 1, 0, 0, "R6 perm none denies privileged");
        access(32'h2000, 1, 0, 0, "R8 miss faults region -1");
        // R7 / R6 overlapping regions
        set_region(3, 32'h1000, 12, 2'b11, 1);
        access(32'h1010, 0, 1, 0, "R7 higher region wins full access");
        set_region(5, 32'h1000, 5, 2'b10, 1);
        access(32'h1004, 0, 1, 0, "R6 user write to read-only faults");
        access(32'h1004, 0, 0, 0, "R6 user read permitted");
        access(32'h1004, 1, 1, 0, "R6 privileged write permitted");
        set_region(6, 32'h1000, 12, 2'b01, 1);
        access(32'h1004, 0, 0, 0, "R7 region 6 priv-only denies user");
        access(32'h1004, 1, 0, 0, "R6 priv-only allows privileged");
        // R9 background map
        wr(1, 32'h5);
        access(32'h9000, 1, 1, 0, "R9 privileged miss permitted");
        access(32'h9000, 0, 0, 0, "R9 unprivileged miss faults");
        // R10 handler context
        wr(1, 32'h1);
        access(32'h1010, 0, 1, 1, "R10 handler bypass");
        wr(1, 32'h3);
        access(32'h2000, 0, 1, 1, "R10 handler checked when enabled");
        // R11 strobe lasts one cycle
        @(negedge clk);
        check(!dec_valid && !dec_fault, "R11 fault one cycle only",
              {62'h0, dec_valid, dec_fault}, 64'h0);
        // R5 small exponent acts as 32 bytes
        wr(1, 32'h1);
        set_region(2, 32'h4000, 2, 2'b11, 1);
        access(32'h401F, 0, 1, 0, "R5 top of 32-byte region");
        access(32'h4020, 0, 1, 0, "R5 just past region");
        access(32'h3FFF, 0, 1, 0, "R5 just below region");
        // Random configurations and accesses
        for (int c = 0; c < 20; c++) begin
            wr(1, {29'h0, 3'($urandom)});
            for (int n = 0; n < 8; n++)
                set_region(n, $urandom % (1 << 16), 3 + $urandom % 11, 2'($urandom), 1'($urandom % 3 != 0));
            for (int k = 0; k < 30; k++)
                access($urandom % (1 << 16), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
                       "R5 R6 R7 R8 R9 R10 random decision");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule